// File: doc/BRIEF.md
# Holdover Exit Frequency Ramp Generator

When a clock loop leaves holdover, its output must move from the frequency it held to the frequency now required. An abrupt jump can disturb downstream logic, so this block produces a sequence of frequency words that walks the output from one value to the other in equal steps. When a start strobe arrives, the block records the held word and the target word. It looks up a per-step increment from a rate select. A serial divider then works out how many steps the move needs, and the block issues those steps at a fixed tick spacing. The last step lands exactly on the target.

A bypass input replaces the ramp with an immediate step to the target. In that case the loop is expected to use its own exit bandwidth, which lies outside this block. The ramp rate and any loop bandwidth are separate settings, and this block touches only the rate. Lock detection, loop filtering and turning the word into a real clock are handled elsewhere.

Top module: `hx_exit_ramp`

## Requirements
- R1: While reset is high and on the first cycle after it falls, freq_o is 0 and busy_o and done_o are 0.
- R2: A start accepted with bypass low gives freq_o equal to hold_freq_i and busy_o high on the next cycle.
- R3: The step increment for rate select s is (2 + (s mod 2)) shifted left by floor(s/2). Any select value at or above RATE_COUNT acts as RATE_COUNT-1.
- R4: Every ramp step except the last changes freq_o by exactly the increment, moving toward the target. Steps occur exactly TICK_DIV cycles apart.
- R5: A ramp takes exactly ceil(|target - hold| / increment) steps. freq_o never passes the target, and it ends equal to the target.
- R6: When a ramp ends, done_o is high for exactly one cycle. In that cycle busy_o is low and freq_o equals the target.
- R7: A start with bypass high sets freq_o to the target on the next cycle and pulses done_o there. busy_o stays low.
- R8: A start strobe, or a change to hold_freq_i or target_freq_i, while busy_o is high has no effect on the ramp in progress or on its end value.
- R9: When hold and target are equal, the ramp takes no steps and ends with freq_o equal to the target.
- R10: busy_o stays high for exactly FW + 1 + steps × TICK_DIV cycles. The first FW + 1 cycles are the planning phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins an exit; accepted only while idle |
| bypass_i | input | 1 | 1: step straight to target, 0: ramp |
| rate_sel_i | input | RATE_SEL_W | Ramp rate select |
| hold_freq_i | input | FW | Frequency word held during holdover |
| target_freq_i | input | FW | Frequency word required after exit |
| freq_o | output | FW | Instantaneous frequency word |
| busy_o | output | 1 | Planning or ramping in progress |
| done_o | output | 1 | One-cycle pulse when the exit completes |

## Verification
The assertions assume that the selected increment is never zero. That holds when FW is wide enough for the largest table entry, and the bench keeps every select it uses inside that range. They also assume that the hold and target words are stable on the cycle a start is accepted. The bench drives all inputs at the falling edge and holds them there. For the ignored-start case, the bench changes both frequency inputs and pulses start during a ramp, then checks that the original target is still the end value at the ports.

// File: rtl/hxr_pkg.sv
package hxr_pkg;
  typedef enum logic [1:0] {
    HX_IDLE = 2'd0,
    HX_PLAN = 2'd1,
    HX_RUN  = 2'd2
  } hx_state_e;
endpackage

// File: rtl/hxr_rate_map.sv
module hxr_rate_map #(
  parameter int FW         = 24,
  parameter int RATE_COUNT = 40,
  parameter int RATE_SEL_W = 6
) (
  input  logic [RATE_SEL_W-1:0] sel_i,
  output logic [FW-1:0]         inc_o
);
  localparam int IDXW = (RATE_COUNT > 1) ? $clog2(RATE_COUNT) : 1;

  logic [FW-1:0]   lut [RATE_COUNT];
  logic [IDXW-1:0] idx;

  // Entries alternate between 2 and 3 times a power of two.
  for (genvar g = 0; g < RATE_COUNT; g++) begin : g_lut
    localparam logic [63:0] RAW = 64'(2 + (g % 2)) << (g / 2);
    assign lut[g] = RAW[FW-1:0];
  end

  always_comb begin
    if (int'({1'b0, sel_i}) >= RATE_COUNT) idx = IDXW'(RATE_COUNT - 1);
    else                                   idx = sel_i[IDXW-1:0];
  end

  assign inc_o = lut[idx];
endmodule

// File: rtl/hxr_ceil_div.sv
module hxr_ceil_div #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dvd_q, dvs_q, quo_q, res_q;
  logic [W:0]    rem_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;

  logic [W:0]    rem_sh, rem_nx;
  logic [W-1:0]  quo_nx;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q[W-1:0], dvd_q[W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
    quo_nx = {quo_q[W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      res_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        dvd_q <= dividend_i;
        dvs_q <= divisor_i;
        quo_q <= '0;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        dvd_q <= {dvd_q[W-2:0], 1'b0};
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          res_q  <= quo_nx + W'(rem_nx != '0);
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = res_q;

  // R5: partial remainder stays below the divisor while dividing
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q < {1'b0, dvs_q}));
  // R10: the iteration count never runs out while dividing
  a_r10_count_live: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/hx_exit_ramp.sv
module hx_exit_ramp
  import hxr_pkg::*;
#(
  parameter int FW         = 24,
  parameter int RATE_COUNT = 40,
  parameter int RATE_SEL_W = 6,
  parameter int TICK_DIV   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  bypass_i,
  input  logic [RATE_SEL_W-1:0] rate_sel_i,
  input  logic [FW-1:0]         hold_freq_i,
  input  logic [FW-1:0]         target_freq_i,
  output logic [FW-1:0]         freq_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int TCW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  hx_state_e      state_q;
  logic [FW-1:0]  freq_q, tgt_r, inc_r, steps_r;
  logic [TCW-1:0] tick_r;
  logic           busy_q, done_q, down_r;

  logic [FW-1:0]  inc_sel, mag;
  logic           down, accept, div_done;
  logic [FW-1:0]  div_quot;

  hxr_rate_map #(.FW(FW), .RATE_COUNT(RATE_COUNT), .RATE_SEL_W(RATE_SEL_W)) u_rate (
    .sel_i (rate_sel_i),
    .inc_o (inc_sel)
  );

  always_comb begin
    down   = target_freq_i < hold_freq_i;
    mag    = down ? (hold_freq_i - target_freq_i) : (target_freq_i - hold_freq_i);
    accept = start_i && (state_q == HX_IDLE);
  end

  hxr_ceil_div #(.W(FW)) u_div (
    .clk        (clk),
    .rst        (rst),
    .start_i    (accept && !bypass_i),
    .dividend_i (mag),
    .divisor_i  (inc_sel),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HX_IDLE;
      freq_q  <= '0;
      tgt_r   <= '0;
      inc_r   <= '0;
      steps_r <= '0;
      tick_r  <= '0;
      down_r  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        HX_IDLE: begin
          if (accept) begin
            tgt_r <= target_freq_i;
            if (bypass_i) begin
              freq_q <= target_freq_i;
              done_q <= 1'b1;
            end else begin
              freq_q  <= hold_freq_i;
              inc_r   <= inc_sel;
              down_r  <= down;
              busy_q  <= 1'b1;
              state_q <= HX_PLAN;
            end
          end
        end
        HX_PLAN: begin
          if (div_done) begin
            if (div_quot == '0) begin
              freq_q  <= tgt_r;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= HX_IDLE;
            end else begin
              steps_r <= div_quot;
              tick_r  <= '0;
              state_q <= HX_RUN;
            end
          end
        end
        HX_RUN: begin
          if (tick_r == TCW'(TICK_DIV - 1)) begin
            tick_r <= '0;
            if (steps_r == FW'(1)) begin
              freq_q  <= tgt_r;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= HX_IDLE;
            end else begin
              freq_q  <= down_r ? (freq_q - inc_r) : (freq_q + inc_r);
              steps_r <= steps_r - 1'b1;
            end
          end else begin
            tick_r <= tick_r + 1'b1;
          end
        end
        default: state_q <= HX_IDLE;
      endcase
    end
  end

  assign freq_o = freq_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R6: completion pulse never overlaps activity
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R6: completion pulse lands on the latched target
  a_r6_done_on_target: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (freq_q == tgt_r));
  // R4: intermediate moves are exactly one increment
  a_r4_step_size: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && (freq_q != $past(freq_q))) |->
      (((freq_q - $past(freq_q)) == inc_r) || (($past(freq_q) - freq_q) == inc_r)));
  // R5: output never passes the target while ramping
  a_r5_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (down_r ? (freq_q >= tgt_r) : (freq_q <= tgt_r)));
  // R8: a strobe while busy leaves the latched target alone
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> (tgt_r == $past(tgt_r)));
  // R7: bypass exit completes at once without going busy
  a_r7_bypass_step: assert property (@(posedge clk) disable iff (rst)
    (accept && bypass_i) |=> (!busy_q && done_q));
endmodule

// File: tb/tb_hx_exit_ramp.sv
module tb_hx_exit_ramp;
  localparam int FW = 16;
  localparam int RC = 20;
  localparam int SW = 5;
  localparam int TD = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          start, byp;
  logic [SW-1:0] rsel;
  logic [FW-1:0] hold, tgt;
  logic [FW-1:0] freq;
  logic          busy, done;

  always #5 clk = ~clk;

  hx_exit_ramp #(.FW(FW), .RATE_COUNT(RC), .RATE_SEL_W(SW), .TICK_DIV(TD)) dut (
    .clk(clk), .rst(rst), .start_i(start), .bypass_i(byp), .rate_sel_i(rsel),
    .hold_freq_i(hold), .target_freq_i(tgt),
    .freq_o(freq), .busy_o(busy), .done_o(done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic int exp_inc(input int sel);
    int s;
    s = (sel >= RC) ? RC - 1 : sel;
    return (2 + s % 2) << (s / 2);
  endfunction

  task automatic ramp(input int h, input int t, input int sel, input bit poke);
    int inc, mag, nsteps, cyc, changes, last, prev, delta;
    @(negedge clk);
    hold = FW'(h); tgt = FW'(t); rsel = SW'(sel); byp = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    inc = exp_inc(sel);
    mag = (t > h) ? t - h : h - t;
    nsteps = (mag + inc - 1) / inc;
    check(int'(freq) == h && busy, "R2",
          $sformatf("freq=%0d busy=%0b exp freq=%0d busy=1", freq, busy, h));
    if (poke) begin
      hold = FW'(h ^ 16'h5a5a); tgt = FW'(t ^ 16'h0f0f); start = 1'b1;
    end
    cyc = 1; changes = 0; last = 0; prev = int'(freq);
    while (busy && cyc < 100000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (int'(freq) != prev) begin
        changes++;
        delta = (int'(freq) > prev) ? int'(freq) - prev : prev - int'(freq);
        if (busy)
          check(delta == inc, "R3", $sformatf("sel=%0d step=%0d exp=%0d", sel, delta, inc));
        if (changes > 1)
          check(cyc - last == TD, "R4", $sformatf("gap=%0d exp=%0d", cyc - last, TD));
        last = cyc;
        prev = int'(freq);
      end
      check((t >= h) ? (int'(freq) <= t && int'(freq) >= h) : (int'(freq) >= t && int'(freq) <= h),
            "R5", $sformatf("freq=%0d outside [%0d,%0d]", freq, h, t));
    end
    check(done && !busy && int'(freq) == t, poke ? "R8" : "R6",
          $sformatf("done=%0b busy=%0b freq=%0d exp 1/0/%0d", done, busy, freq, t));
    check(changes == nsteps, (mag == 0) ? "R9" : "R5",
          $sformatf("steps=%0d exp=%0d", changes, nsteps));
    check(cyc - 1 == FW + 1 + nsteps * TD, "R10",
          $sformatf("busy cycles=%0d exp=%0d", cyc - 1, FW + 1 + nsteps * TD));
    @(negedge clk);
    check(!done && int'(freq) == t, "R6", $sformatf("done=%0b freq=%0d exp 0/%0d", done, freq, t));
  endtask

  task automatic bypass_exit(input int h, input int t);
    @(negedge clk);
    hold = FW'(h); tgt = FW'(t); rsel = '0; byp = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; byp = 1'b0;
    check(int'(freq) == t && done && !busy, "R7",
          $sformatf("freq=%0d done=%0b busy=%0b exp %0d/1/0", freq, done, busy, t));
    @(negedge clk);
    check(!done && !busy && int'(freq) == t, "R7",
          $sformatf("done=%0b busy=%0b freq=%0d exp 0/0/%0d", done, busy, freq, t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sels[22];
    rst = 1'b1; start = 1'b0; byp = 1'b0; rsel = '0; hold = '0; tgt = '0;
    repeat (3) @(negedge clk);
    check(freq == '0 && !busy && !done, "R1",
          $sformatf("in reset freq=%0d busy=%0b done=%0b exp 0/0/0", freq, busy, done));
    rst = 1'b0;
    @(negedge clk);
    check(freq == '0 && !busy && !done, "R1",
          $sformatf("after reset freq=%0d busy=%0b done=%0b exp 0/0/0", freq, busy, done));

    for (int i = 0; i < RC; i++) sels[i] = i;
    sels[RC] = 25; sels[RC + 1] = 31;
    foreach (sels[j]) begin
      for (int k = 0; k < 4; k++) begin
        for (int r = 0; r < 2; r++) begin
          ramp(30000, 30000 + exp_inc(sels[j]) * k + r, sels[j], 1'b0);
          if (k != 0 || r != 0)
            ramp(30000, 30000 - exp_inc(sels[j]) * k - r, sels[j], 1'b0);
        end
      end
    end
    ramp(0, 65535, 19, 1'b0);
    ramp(65535, 0, 19, 1'b0);
    ramp(1000, 1000, 3, 1'b0);
    ramp(5000, 5013, 2, 1'b1);
    ramp(5000, 4001, 6, 1'b1);
    bypass_exit(1234, 60000);
    bypass_exit(60000, 7);
    bypass_exit(500, 500);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule